// File: doc/BRIEF.md
# DRAM Port Access-Start Sequencer

This block decides when one processor port's DRAM access may begin and how long it stays open. A request is seen when the address-latch strobe and chip select are both high at a rising clock edge. If nothing stands in the way, the row strobe goes high on that same edge. Three things can stand in the way: a refresh in progress, an access by the other port, or a precharge interval that has not yet run out. While any of them holds, the request is kept pending, and the row strobe goes high on the first edge at which all of them have cleared.

A fixed number of clocks after the row strobe rises, the sequencer raises an acknowledge. From then on it samples the access-request line at every edge. The access closes on the first edge where that line is seen low: the row strobe and the acknowledge drop together, and a precharge countdown starts. A mode bit, loaded through a programming enable, selects synchronous operation (0). With the bit at 1 no access is started.

Top module: `port_access_seq`

## Requirements
- R1: A synchronous reset drives rowStrobe and accAck low, clears the mode bit to 0 and marks precharge as met. A request on the first edge after reset therefore raises rowStrobe at that edge.
- R2: In mode 0, with the sequencer idle, latchStrobe=1 and chipSel=1 sampled at an edge form a request. If precharge is met and both busy inputs are low at that edge, rowStrobe is 1 after that same edge.
- R3: While refreshBusy or otherPortBusy is sampled high, rowStrobe stays low. The request stays pending after latchStrobe and chipSel drop, and rowStrobe rises on the first edge at which both busy inputs are sampled low.
- R4: accAck rises exactly ACK_DELAY edges after the edge where rowStrobe rose (default 2). accAck is never high while rowStrobe is low.
- R5: After accAck is high, accReq is sampled at every edge. The access ends on the first edge where accReq is sampled low, and rowStrobe and accAck fall on that same edge. chipSel going low during the access has no effect.
- R6: After an access ends at edge E, a request arriving at edge E+1 raises rowStrobe exactly at edge E+PRE_CLKS (default 3). rowStrobe therefore stays low for at least PRE_CLKS clock periods.
- R7: When refreshBusy and a new request are sampled on the same edge, refresh wins. rowStrobe stays low, and the request is served once refreshBusy is sampled low.
- R8: progMode is loaded into the mode bit at any edge with progEn=1. With the mode bit at 1, requests are ignored and rowStrobe stays low. Loading 0 restores normal operation.
- R9: Protocol rule for the driver: latchStrobe must be low no later than the clock period in which accReq is sampled low to end the access.
- R10: accReq sampled low before accAck is high does not end the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all inputs synchronous to it |
| rst | input | 1 | Synchronous reset, active high |
| progEn | input | 1 | Programming enable; loads progMode into the mode bit |
| progMode | input | 1 | Mode value to load (0 = synchronous, 1 = no access start) |
| latchStrobe | input | 1 | Address-latch strobe from the processor |
| chipSel | input | 1 | Chip select for this DRAM port |
| accReq | input | 1 | Access-request line; held high to keep the access open |
| refreshBusy | input | 1 | High while a refresh is in progress |
| otherPortBusy | input | 1 | High while the other port is accessing DRAM |
| rowStrobe | output | 1 | Row strobe to the DRAM, active high |
| accAck | output | 1 | Acknowledge to the processor, active high |

## Verification
The collision of interest is a new request meeting a blocking condition on the same edge. This is either a busy input or a precharge countdown still running right after a previous access closed. The bench provokes the busy case by raising refreshBusy, otherPortBusy or both for set lengths on the very edge the request is sampled. It provokes the precharge case by issuing a request one edge after an access ends. In each case it judges the exact edge on which rowStrobe rises against the length of the blocking interval. It also checks that the request survives latchStrobe and chipSel dropping in the meantime.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_WAIT_ACK = 2'd2,
    ST_HOLD    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic progLoad;
    logic rowSet;
    logic ackStart;
    logic ackSet;
    logic accEnd;
  } seqCtl_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    progEn,
  input  logic    latchStrobe,
  input  logic    chipSel,
  input  logic    accReq,
  input  logic    refreshBusy,
  input  logic    otherPortBusy,
  input  logic    modeBit,
  input  logic    preMet,
  input  logic    ackDue,
  output seqCtl_t ctl
);

  seqState_t state, stateNext;
  logic reqSeen;
  logic clearToGo;

  assign reqSeen   = latchStrobe && chipSel && !modeBit;
  assign clearToGo = preMet && !refreshBusy && !otherPortBusy;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    ctl.progLoad = progEn;
    unique case (state)
      ST_IDLE: begin
        if (reqSeen) begin
          if (clearToGo) begin
            ctl.rowSet   = 1'b1;
            ctl.ackStart = 1'b1;
            stateNext    = ST_WAIT_ACK;
          end else begin
            stateNext = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (clearToGo) begin
          ctl.rowSet   = 1'b1;
          ctl.ackStart = 1'b1;
          stateNext    = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        if (ackDue) begin
          ctl.ackSet = 1'b1;
          stateNext  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!accReq) begin
          ctl.accEnd = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R8: with the mode bit at 1 an idle sequencer never leaves idle
  p_mode1_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (modeBit && state == ST_IDLE) |=> state == ST_IDLE);

  // R3: a pending request never leaves pending while a busy input is high
  p_pend_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PEND && (refreshBusy || otherPortBusy)) |=> state == ST_PEND);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ACK_DELAY = 2,
  parameter int PRE_CLKS  = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  seqCtl_t ctl,
  input  logic    progMode,
  output logic    modeBit,
  output logic    preMet,
  output logic    ackDue,
  output logic    rowStrobe,
  output logic    accAck
);

  localparam int ACK_W = $clog2(ACK_DELAY + 1);
  localparam int PRE_W = $clog2(PRE_CLKS + 1);
  localparam logic [ACK_W-1:0] ACK_LOAD = ACK_W'(ACK_DELAY - 1);
  localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(PRE_CLKS - 1);

  logic [ACK_W-1:0] ackCnt;
  logic [PRE_W-1:0] preCnt;
  logic modeReg, rowReg, ackReg;

  always_ff @(posedge clk) begin
    if (rst)               modeReg <= 1'b0;
    else if (ctl.progLoad) modeReg <= progMode;
  end

  always_ff @(posedge clk) begin
    if (rst)                 preCnt <= '0;
    else if (ctl.accEnd)     preCnt <= PRE_LOAD;
    else if (preCnt != '0)   preCnt <= preCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ackCnt <= '0;
    else if (ctl.ackStart)   ackCnt <= ACK_LOAD;
    else if (ackCnt != '0)   ackCnt <= ackCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowReg <= 1'b0;
      ackReg <= 1'b0;
    end else begin
      if (ctl.accEnd)      rowReg <= 1'b0;
      else if (ctl.rowSet) rowReg <= 1'b1;
      if (ctl.accEnd)      ackReg <= 1'b0;
      else if (ctl.ackSet) ackReg <= 1'b1;
    end
  end

  assign modeBit   = modeReg;
  assign preMet    = (preCnt == '0);
  assign ackDue    = (ackCnt == '0);
  assign rowStrobe = rowReg;
  assign accAck    = ackReg;

  // R6: the control never asks for row strobe while precharge is running
  p_no_early_row_r6: assert property (@(posedge clk) disable iff (rst)
    (preCnt != '0) |-> !ctl.rowSet);

  // R5: an access ends only while the acknowledge is high
  p_end_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.accEnd |-> ackReg);

endmodule

// File: rtl/port_access_seq.sv
module port_access_seq
  import seq_pkg::*;
#(
  parameter int ACK_DELAY = 2,
  parameter int PRE_CLKS  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic progEn,
  input  logic progMode,
  input  logic latchStrobe,
  input  logic chipSel,
  input  logic accReq,
  input  logic refreshBusy,
  input  logic otherPortBusy,
  output logic rowStrobe,
  output logic accAck
);

  seqCtl_t ctl;
  logic modeBit, preMet, ackDue;

  seq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .progEn       (progEn),
    .latchStrobe  (latchStrobe),
    .chipSel      (chipSel),
    .accReq       (accReq),
    .refreshBusy  (refreshBusy),
    .otherPortBusy(otherPortBusy),
    .modeBit      (modeBit),
    .preMet       (preMet),
    .ackDue       (ackDue),
    .ctl          (ctl)
  );

  seq_datapath #(
    .ACK_DELAY(ACK_DELAY),
    .PRE_CLKS (PRE_CLKS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .progMode (progMode),
    .modeBit  (modeBit),
    .preMet   (preMet),
    .ackDue   (ackDue),
    .rowStrobe(rowStrobe),
    .accAck   (accAck)
  );

  // R3/R7: row strobe cannot rise on an edge where a busy input is high
  p_row_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (!rowStrobe && (refreshBusy || otherPortBusy)) |=> !rowStrobe);

  // R4: acknowledge only while row strobe is high
  p_ack_needs_row_r4: assert property (@(posedge clk) disable iff (rst)
    accAck |-> rowStrobe);

  // R4: acknowledge rises only after row strobe was already high
  p_ack_after_row_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(accAck) |-> $past(rowStrobe));

  // R5: row strobe and acknowledge fall together
  p_end_together_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rowStrobe) |-> $fell(accAck));

  // R5: a held request keeps the access open
  p_hold_open_r5: assert property (@(posedge clk) disable iff (rst)
    (accAck && accReq) |=> accAck);

endmodule

// File: tb/tb_port_access_seq.sv
module tb_port_access_seq;

  localparam int ACK_D = 2;
  localparam int PRE_C = 3;
  localparam int NVEC  = 6;
  // fields: [15:12] refresh busy length, [11:8] other-port busy length,
  //         [7:4] extra edges accReq held after ack, [3:0] expected wait edges
  localparam logic [15:0] VECS [NVEC] = '{
    16'h0000, 16'h2012, 16'h0303, 16'h1424, 16'h5205, 16'h3333
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic progEn = 1'b0, progMode = 1'b0;
  logic latchStrobe = 1'b0, chipSel = 1'b0, accReq = 1'b0;
  logic refreshBusy = 1'b0, otherPortBusy = 1'b0;
  logic rowStrobe, accAck;

  int checks = 0;
  int failures = 0;
  int latchViol = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  port_access_seq #(.ACK_DELAY(ACK_D), .PRE_CLKS(PRE_C)) dut (
    .clk(clk), .rst(rst), .progEn(progEn), .progMode(progMode),
    .latchStrobe(latchStrobe), .chipSel(chipSel), .accReq(accReq),
    .refreshBusy(refreshBusy), .otherPortBusy(otherPortBusy),
    .rowStrobe(rowStrobe), .accAck(accAck)
  );

  // R9 protocol monitor: latch strobe must be low when the access is closed
  always @(posedge clk)
    if (!rst && accAck && !accReq && latchStrobe) latchViol++;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic closeAccess();
    accReq = 1'b0;
    for (int i = 0; i < ACK_D + 1; i++) tick();
    idle(PRE_C + 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    check("R1 rowStrobe after reset", rowStrobe, 1'b0);
    check("R1 accAck after reset", accAck, 1'b0);
    // R1: precharge met and mode 0 straight after reset
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    latchStrobe = 1'b0; chipSel = 1'b0;
    check("R1 request right after reset", rowStrobe, 1'b1);
    closeAccess();

    // vector walk: R2, R3, R7, R4, R5
    for (int v = 0; v < NVEC; v++) begin
      int refLen, othLen, holdLen, expWait;
      refLen  = int'(VECS[v][15:12]);
      othLen  = int'(VECS[v][11:8]);
      holdLen = int'(VECS[v][7:4]);
      expWait = int'(VECS[v][3:0]);
      latchStrobe = 1'b1; chipSel = 1'b1;
      refreshBusy = (refLen > 0); otherPortBusy = (othLen > 0);
      for (int e = 0; e <= expWait; e++) begin
        tick();
        if (e == 0) begin
          latchStrobe = 1'b0; chipSel = 1'b0; accReq = 1'b1;
        end
        refreshBusy   = (e + 1 < refLen);
        otherPortBusy = (e + 1 < othLen);
        if (e == expWait)
          check($sformatf("R2/R3 vec%0d row rises at wait %0d", v, expWait), rowStrobe, 1'b1);
        else if (refLen > e)
          check($sformatf("R7 vec%0d refresh holds row at %0d", v, e), rowStrobe, 1'b0);
        else
          check($sformatf("R3 vec%0d busy holds row at %0d", v, e), rowStrobe, 1'b0);
      end
      for (int k = 1; k <= ACK_D; k++) begin
        tick();
        check($sformatf("R4 vec%0d ack at +%0d", v, k), accAck, (k == ACK_D));
      end
      for (int h = 0; h < holdLen; h++) begin
        tick();
        check($sformatf("R5 vec%0d held open %0d", v, h), rowStrobe & accAck, 1'b1);
      end
      accReq = 1'b0;
      tick();
      check($sformatf("R5 vec%0d row falls at end", v), rowStrobe, 1'b0);
      check($sformatf("R5 vec%0d ack falls at end", v), accAck, 1'b0);
      idle(PRE_C + 1);
    end

    // R6: request one edge after an access ends
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    latchStrobe = 1'b0; chipSel = 1'b0; accReq = 1'b1;
    idle(ACK_D);
    accReq = 1'b0;
    tick();
    check("R5 end before precharge test", rowStrobe, 1'b0);
    latchStrobe = 1'b1; chipSel = 1'b1;
    for (int k = 1; k <= PRE_C; k++) begin
      tick();
      latchStrobe = 1'b0; chipSel = 1'b0; accReq = 1'b1;
      check($sformatf("R6 row after end +%0d", k), rowStrobe, (k == PRE_C));
    end
    closeAccess();

    // R10: accReq low before ack does not end the access
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    latchStrobe = 1'b0; chipSel = 1'b0;
    tick();
    check("R10 row kept before ack", rowStrobe, 1'b1);
    check("R10 ack not yet", accAck, 1'b0);
    tick();
    check("R10 ack still rises", accAck, 1'b1);
    tick();
    check("R10 ends once sampled after ack", rowStrobe | accAck, 1'b0);
    idle(PRE_C + 1);

    // R8: mode 1 ignores requests, mode 0 restores
    progEn = 1'b1; progMode = 1'b1;
    tick();
    progEn = 1'b0;
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    latchStrobe = 1'b0; chipSel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check($sformatf("R8 mode1 no row %0d", k), rowStrobe, 1'b0);
      tick();
    end
    progEn = 1'b1; progMode = 1'b0;
    tick();
    progEn = 1'b0;
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    latchStrobe = 1'b0; chipSel = 1'b0;
    check("R8 mode0 restored", rowStrobe, 1'b1);
    closeAccess();

    // R5/R9: latch held several clocks, chip select dropped mid-access
    latchStrobe = 1'b1; chipSel = 1'b1;
    tick();
    accReq = 1'b1; chipSel = 1'b0;
    idle(ACK_D);
    check("R5 ack with chipSel low", accAck, 1'b1);
    latchStrobe = 1'b0;
    tick();
    check("R5 still open after latch drop", rowStrobe, 1'b1);
    accReq = 1'b0;
    tick();
    check("R5 closed", rowStrobe | accAck, 1'b0);
    idle(PRE_C + 1);
    check("R5 no restart after close", rowStrobe, 1'b0);
    checks++;
    if (latchViol != 0) begin
      failures++;
      $display("FAIL R9 latch violations actual=%0d expected=0", latchViol);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule